// File: doc/BRIEF.md
# Microcoded State Machine

This block is a control state machine whose whole behaviour (every transition and every output value) lives in a small read-only memory instead of in decode gates. The current state is held in a 3-bit binary code. On each rising clock edge that code is joined with the three input bits to form a 6-bit address, and the 64-word memory is read at that address. Each 7-bit word carries the next state code in its upper three bits and four output bits in its lower four bits. Both fields are loaded into registers on the same edge. The outputs therefore always show the word fetched for the previous (state, inputs) pair.

The memory contents are computed at elaboration by a constant function in the package, and that function acts as the microcode program. The program drives a small job sequencer with eight states:
- IDLE (code 0), ARM (1), LOAD (2), RUN (3), HOLD (4), DRAIN (5), DONE (6), FAULT (7).
- Its inputs are a start request `go` (in_i[0]), a stop request `stop` (in_i[1]) and an error flag `err` (in_i[2]).
- Its transitions are named in the requirements below.
- A synchronous reset returns the machine to IDLE and clears the outputs to the word stored for IDLE with all inputs low.

Top module: `ucode_fsm`

## Requirements
- R1: While rst_i is high at a rising edge, the state returns to IDLE and out_o becomes 4'b0000 on that edge, whatever in_i holds.
- R2: The address is {state, in_i}, with the state code in the upper bits. The state register and out_o both load from the same word on the edge that samples in_i. out_o therefore changes one edge after the input pattern that selected it.
- R3: With err (in_i[2]) high, every state moves to FAULT. FAULT is left only to IDLE, and only when stop is high and err is low.
- R4: IDLE moves to ARM when go (in_i[0]) is high, and otherwise stays in IDLE.
- R5: ARM moves to IDLE when stop (in_i[1]) is high, which takes priority over go. ARM moves to LOAD when go alone is high, and otherwise stays in ARM.
- R6: With err low, LOAD always moves to RUN, DRAIN always moves to DONE, and DONE always moves to IDLE, whatever go and stop hold.
- R7: With err low, RUN moves to HOLD on stop (stop beats go), to DRAIN on go alone, and otherwise stays. HOLD moves to IDLE on stop (stop beats go), to RUN on go alone, and otherwise stays.
- R8: The output bits are taken from the state at lookup time and from the inputs:
  - out_o[0] is high when that state is LOAD, RUN, HOLD or DRAIN.
  - out_o[1] is high when that state is DONE.
  - out_o[2] is high when the next state is FAULT.
  - out_o[3] is go AND'ed with (that state is IDLE, RUN or HOLD).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous active-high reset |
| in_i | input | 3 | Machine inputs: [0] go, [1] stop, [2] err |
| out_o | output | 4 | Registered outputs: [0] busy, [1] done, [2] fault, [3] ack |

## Verification
Directed patterns walk the machine through all eight states. Simultaneous go and stop in ARM, RUN and HOLD separate the stop-priority entries from the go entries of the same state. The input values go, stop and all-low are each applied inside the same state, which shows that the address really carries the input bits: each value has to produce a different successor. The err flag is raised from several states, and stop with err is applied inside FAULT, to show that err overrides every other entry. A reset arriving mid-run with inputs active, followed by a long pseudo-random input sweep, is compared cycle by cycle against a reference model written from the requirements.

// File: rtl/ucode_pkg.sv
package ucode_pkg;

    localparam int ST_W   = 3;
    localparam int IN_W   = 3;
    localparam int OUT_W  = 4;
    localparam int ADDR_W = ST_W + IN_W;
    localparam int WORD_W = ST_W + OUT_W;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef enum logic [ST_W-1:0] {
        ST_IDLE  = 3'd0,
        ST_ARM   = 3'd1,
        ST_LOAD  = 3'd2,
        ST_RUN   = 3'd3,
        ST_HOLD  = 3'd4,
        ST_DRAIN = 3'd5,
        ST_DONE  = 3'd6,
        ST_FAULT = 3'd7
    } state_e;

    typedef struct packed {
        state_e             nxt;
        logic [OUT_W-1:0]   outs;
    } word_t;

    // Microcode program: computes the memory word for one address.
    // Address layout {state, err, stop, go}: the state code sits in the upper bits.
    function automatic word_t ucode_word(input logic [ADDR_W-1:0] addr);
        state_e cur;
        state_e nx;
        logic   go;
        logic   stop;
        logic   err;
        logic   busy;
        logic   done;
        logic   ack;
        cur  = state_e'(addr[ADDR_W-1:IN_W]);
        go   = addr[0];
        stop = addr[1];
        err  = addr[2];
        nx   = cur;
        unique case (cur)
            ST_IDLE:  nx = go ? ST_ARM : ST_IDLE;
            ST_ARM:   nx = stop ? ST_IDLE : (go ? ST_LOAD : ST_ARM);
            ST_LOAD:  nx = ST_RUN;
            ST_RUN:   nx = stop ? ST_HOLD : (go ? ST_DRAIN : ST_RUN);
            ST_HOLD:  nx = stop ? ST_IDLE : (go ? ST_RUN : ST_HOLD);
            ST_DRAIN: nx = ST_DONE;
            ST_DONE:  nx = ST_IDLE;
            ST_FAULT: nx = stop ? ST_IDLE : ST_FAULT;
        endcase
        if (err) begin
            nx = ST_FAULT;
        end
        busy = (cur == ST_LOAD) || (cur == ST_RUN) || (cur == ST_HOLD) || (cur == ST_DRAIN);
        done = (cur == ST_DONE);
        ack  = go && ((cur == ST_IDLE) || (cur == ST_RUN) || (cur == ST_HOLD));
        ucode_word.nxt  = nx;
        ucode_word.outs = {ack, (nx == ST_FAULT), done, busy};
    endfunction

endpackage

// File: rtl/ucode_addr_gen.sv
module ucode_addr_gen #(
    parameter int STATE_W = 3,
    parameter int IN_W    = 3,
    localparam int ADDR_W = STATE_W + IN_W
) (
    input  logic [STATE_W-1:0] state_i,
    input  logic [IN_W-1:0]    in_i,
    output logic [ADDR_W-1:0]  addr_o
);
    // State code in the upper address bits, inputs in the lower ones.
    assign addr_o = {state_i, in_i};
endmodule

// File: rtl/ucode_rom.sv
module ucode_rom #(
    parameter int ADDR_W = ucode_pkg::ADDR_W,
    parameter int WORD_W = ucode_pkg::WORD_W,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [WORD_W-1:0] rd_word_o
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Contents fixed at elaboration from the microcode function.
    for (genvar a = 0; a < DEPTH; a++) begin : g_word
        assign mem[a] = WORD_W'(ucode_pkg::ucode_word(ucode_pkg::ADDR_W'(a)));
    end

    assign rd_word_o = mem[rd_addr_i];
endmodule

// File: rtl/ucode_fsm.sv
module ucode_fsm #(
    parameter int STATE_W = ucode_pkg::ST_W,
    parameter int IN_W    = ucode_pkg::IN_W,
    parameter int OUT_W   = ucode_pkg::OUT_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [IN_W-1:0]  in_i,
    output logic [OUT_W-1:0] out_o
);
    import ucode_pkg::*;

    localparam int ADDR_W = STATE_W + IN_W;
    localparam int WORD_W = STATE_W + OUT_W;
    localparam word_t RST_WORD = ucode_word('0);

    state_e            state_q;
    logic [ADDR_W-1:0] addr;
    logic [WORD_W-1:0] rd_raw;
    word_t             rd_word;

    ucode_addr_gen #(.STATE_W(STATE_W), .IN_W(IN_W)) u_addr (
        .state_i (state_q),
        .in_i    (in_i),
        .addr_o  (addr)
    );

    ucode_rom #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_rom (
        .rd_addr_i (addr),
        .rd_word_o (rd_raw)
    );

    assign rd_word = word_t'(rd_raw);

    // State register: the next-state field of the fetched word.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= RST_WORD.nxt;
        end else begin
            state_q <= rd_word.nxt;
        end
    end

    // Output register: loaded on the same edge from the same word.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            out_o <= RST_WORD.outs;
        end else begin
            out_o <= rd_word.outs;
        end
    end

    // R3: err forces FAULT from any state
    p_err_fault_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        in_i[2] |=> state_q == ST_FAULT);

    // R3: FAULT held while stop is low
    p_fault_hold_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_FAULT && !in_i[1]) |=> state_q == ST_FAULT);

    // R4: IDLE with no inputs stays idle and quiet
    p_idle_wait_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_IDLE && in_i == '0) |=> (state_q == ST_IDLE && out_o == '0));

    // R6: LOAD always advances to RUN without err
    p_load_run_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_LOAD && !in_i[2]) |=> state_q == ST_RUN);

    // R7: stop wins over go in RUN
    p_stop_prio_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_RUN && in_i[1] && !in_i[2]) |=> state_q == ST_HOLD);

    // R8: fault flag tracks the state loaded with it
    p_fault_flag_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        out_o[2] == (state_q == ST_FAULT));

    // R2: outputs follow the word fetched one edge earlier
    p_done_lag_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_DONE) |=> out_o[1]);
endmodule

// File: tb/ucode_fsm_bench.sv
module ucode_fsm_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] in  = 3'b000;
    logic [3:0] out;

    int checks = 0;
    int errors = 0;
    int mst    = 0;   // reference-model state: 0 IDLE .. 7 FAULT
    bit finished = 1'b0;

    logic [3:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    ucode_fsm u_ucode_fsm (.clk_i(clk), .rst_i(rst), .in_i(in), .out_o(out));

    function automatic int model_next(int s, logic [2:0] v);
        int n;
        if (v[2]) return 7;
        case (s)
            0: n = v[0] ? 1 : 0;
            1: n = v[1] ? 0 : (v[0] ? 2 : 1);
            2: n = 3;
            3: n = v[1] ? 4 : (v[0] ? 5 : 3);
            4: n = v[1] ? 0 : (v[0] ? 3 : 4);
            5: n = 6;
            6: n = 0;
            default: n = v[1] ? 0 : 7;
        endcase
        return n;
    endfunction

    function automatic logic [3:0] model_out(int s, logic [2:0] v);
        logic [3:0] o;
        o[0] = (s >= 2 && s <= 5);
        o[1] = (s == 6);
        o[2] = (model_next(s, v) == 7);
        o[3] = v[0] && (s == 0 || s == 3 || s == 4);
        return o;
    endfunction

    task automatic drive(input logic [2:0] v, input string tag);
        @(negedge clk);
        rst = 1'b0;
        in  = v;
        exp_q.push_back(model_out(mst, v));
        tag_q.push_back(tag);
        mst = model_next(mst, v);
    endtask

    task automatic drive_rst(input logic [2:0] v, input string tag);
        @(negedge clk);
        rst = 1'b1;
        in  = v;
        exp_q.push_back(4'b0000);
        tag_q.push_back(tag);
        mst = 0;
    endtask

    // Monitor: pops one expectation per edge once results are due.
    always @(posedge clk) begin
        logic [3:0] e;
        string      t;
        #1;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (out !== e) begin
                errors++;
                $display("FAIL %s: out=%b expected=%b", t, out, e);
            end
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        drive_rst(3'b101, "R1 reset with inputs active");
        drive(3'b000, "R4 idle wait");
        drive(3'b001, "R4 idle go to arm");
        drive(3'b000, "R5 arm wait");
        drive(3'b011, "R5 arm stop beats go");
        drive(3'b001, "R4 idle go again");
        drive(3'b001, "R5 arm go to load");
        drive(3'b011, "R6 load ignores go/stop");
        drive(3'b000, "R7 run wait");
        drive(3'b001, "R7 run go to drain");
        drive(3'b010, "R6 drain to done");
        drive(3'b001, "R6 done to idle");
        drive(3'b000, "R2 idle after done");
        drive(3'b001, "R4 idle to arm");
        drive(3'b001, "R5 arm to load");
        drive(3'b000, "R6 load to run");
        drive(3'b010, "R7 run stop to hold");
        drive(3'b000, "R7 hold wait");
        drive(3'b001, "R7 hold go to run");
        drive(3'b011, "R7 run stop beats go");
        drive(3'b011, "R7 hold stop beats go");
        drive(3'b100, "R3 idle err to fault");
        drive(3'b001, "R3 fault ignores go");
        drive(3'b110, "R3 fault err beats stop");
        drive(3'b010, "R3 fault stop to idle");
        drive(3'b001, "R8 ack in idle");
        drive(3'b101, "R3 arm err to fault");
        drive(3'b010, "R3 fault exit");
        drive(3'b001, "R4 to arm");
        drive(3'b001, "R5 to load");
        drive(3'b000, "R6 to run");
        drive(3'b001, "R7 run to drain");
        drive(3'b100, "R3 drain err to fault");
        drive(3'b010, "R3 fault exit again");
        drive(3'b001, "R4 to arm");
        drive(3'b001, "R5 to load");
        drive(3'b001, "R6 to run");
        drive_rst(3'b001, "R1 reset mid-run");
        drive(3'b000, "R1 idle after reset");
        lfsr = 16'hACE1;
        for (int i = 0; i < 200; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive({(lfsr[5:3] == 3'b000), lfsr[1:0]}, "R8 sweep");
        end
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: out=%b expected=finish", out);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule